// File: doc/BRIEF.md
# EDH Error Flag Capture Register

This block watches the words of error detection and handling (EDH) packets that an upstream detector has already found in a serial digital video stream. Three words of each packet carry error flag sets: one for the ancillary data area, one for the active picture and one for the full field. The block gathers the three sets in a staging area. It copies them into a host-readable status register in a single step, and only when the packet's checksum word arrives with a good CRC result.

The two video fields share one register, so the packet that arrives last always wins. The register is sticky. A host read leaves it unchanged, and if packets stop arriving it keeps the last set it captured. A busy output is high while a packet is being collected. The host should not read during those cycles.

The caller drives a valid strobe with each packet word, along with the word's position in the packet (0 is the first word of the packet). A CRC-error flag goes with the checksum word.

Top module: `edh_flag_capture`

## Requirements
- R1: After a synchronous reset, `flags` is all zeros and `upd_busy` is low.
- R2: Flag bits [5:1] of the word at index 12 go to `flags[4:0]` (ancillary area). The word at index 13 goes to `flags[9:5]` (active picture) and the word at index 14 goes to `flags[14:10]` (full field). Other word bits are ignored. The commit takes place in the cycle after the checksum word at index 22 is accepted.
- R3: `flags` changes only in the cycle after an accepted checksum word. It never changes partway through a packet.
- R4: When `crc_err` is high with the checksum word, `flags` keeps its previous value.
- R5: A pulse on `rd_stb` never changes `flags`.
- R6: While no words arrive, `flags` holds its value indefinitely.
- R7: A later good packet replaces the whole register, from either field. Bits that were set earlier are cleared if the new packet has them clear.
- R8: `upd_busy` rises in the cycle after a word at index 0 is accepted. It falls in the cycle after the checksum word is accepted, whatever the CRC result.
- R9: When a new index-0 word arrives before all three flag words of the current packet have been seen, those earlier flag words are discarded. A checksum that follows without the three flag words of the new packet leaves `flags` unchanged.
- R10: Idle cycles between packet words (`word_valid` low) do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Packet word present this cycle |
| word_idx | input | 6 | Position of the word in the packet, 0 = first |
| word_data | input | 10 | Packet word |
| crc_err | input | 1 | CRC check failed for this packet; sampled with the checksum word |
| rd_stb | input | 1 | Host read strobe |
| flags | output | 15 | Captured flags: {full field, active picture, ancillary} |
| upd_busy | output | 1 | Collection in progress; a read is not safe |

## Verification
Wrong staging or commit logic shows on `flags` in the cycle after the checksum word. The symptoms are a wrong area field, a swapped slot, or an update that should have been blocked by a CRC error or a restarted packet. A stuck or lost busy state shows on `upd_busy` one cycle after the index-0 word or after the checksum word. An update that leaks in early, or a clear caused by a read, shows as a change on `flags` in a cycle with no commit. The bench compares both outputs with a behavioural model on every clock, so any such error is reported within one cycle of when it happens.

// File: rtl/edh_flag_pkg.sv
package edh_flag_pkg;
  localparam int unsigned AREA_N  = 3;
  localparam int unsigned FLAG_N  = 5;
  localparam int unsigned REG_W   = AREA_N * FLAG_N;
  typedef logic [FLAG_N-1:0] area_flags_t;
endpackage

// File: rtl/edh_flag_stage.sv
module edh_flag_stage
  import edh_flag_pkg::*;
#(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned FLAG_LSB = 1,
  parameter int unsigned ANC_IDX  = 12,
  parameter int unsigned AP_IDX   = 13,
  parameter int unsigned FF_IDX   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  output logic [REG_W-1:0]  stage_flags,
  output logic              all_seen
);
  logic [AREA_N-1:0] seen;

  for (genvar a = 0; a < AREA_N; a++) begin : g_area
    localparam int unsigned SLOT = (a == 0) ? ANC_IDX : (a == 1) ? AP_IDX : FF_IDX;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_flags[a*FLAG_N +: FLAG_N] <= '0;
        seen[a] <= 1'b0;
      end else if (word_valid) begin
        if (word_idx == '0) begin
          seen[a] <= 1'b0;
        end else if (word_idx == IDX_W'(SLOT)) begin
          stage_flags[a*FLAG_N +: FLAG_N] <= word_data[FLAG_LSB +: FLAG_N];
          seen[a] <= 1'b1;
        end
      end
    end
    // R9: a packet start forgets the slot
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
      (word_valid && word_idx == '0) |=> !seen[a]);
  end

  assign all_seen = &seen;

  logic unused_bits;
  assign unused_bits = ^word_data;
endmodule

// File: rtl/edh_commit_ctrl.sv
module edh_commit_ctrl #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned CSUM_IDX = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  input  logic [IDX_W-1:0] word_idx,
  input  logic             crc_err,
  input  logic             all_seen,
  output logic             commit,
  output logic             upd_busy
);
  logic is_start, is_csum;
  assign is_start = word_valid && (word_idx == '0);
  assign is_csum  = word_valid && (word_idx == IDX_W'(CSUM_IDX));
  assign commit   = is_csum && upd_busy && all_seen && !crc_err;

  always_ff @(posedge clk) begin
    if (rst)           upd_busy <= 1'b0;
    else if (is_start) upd_busy <= 1'b1;
    else if (is_csum)  upd_busy <= 1'b0;
  end

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
    is_start |=> upd_busy);
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (is_csum && !is_start) |=> !upd_busy);
  p_crc_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> !commit);
endmodule

// File: rtl/edh_flag_capture.sv
module edh_flag_capture
  import edh_flag_pkg::*;
#(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned FLAG_LSB = 1,
  parameter int unsigned ANC_IDX  = 12,
  parameter int unsigned AP_IDX   = 13,
  parameter int unsigned FF_IDX   = 14,
  parameter int unsigned CSUM_IDX = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic              crc_err,
  input  logic              rd_stb,
  output logic [REG_W-1:0]  flags,
  output logic              upd_busy
);
  logic [REG_W-1:0] stage_flags;
  logic             all_seen;
  logic             commit;

  edh_flag_stage #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .FLAG_LSB(FLAG_LSB),
    .ANC_IDX(ANC_IDX), .AP_IDX(AP_IDX), .FF_IDX(FF_IDX)
  ) u_stage (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .stage_flags(stage_flags), .all_seen(all_seen)
  );

  edh_commit_ctrl #(.IDX_W(IDX_W), .CSUM_IDX(CSUM_IDX)) u_ctrl (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_idx(word_idx),
    .crc_err(crc_err), .all_seen(all_seen), .commit(commit), .upd_busy(upd_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)         flags <= '0;
    else if (commit) flags <= stage_flags;
  end

  logic is_csum_word;
  assign is_csum_word = word_valid && (word_idx == IDX_W'(CSUM_IDX));

  p_atomic_r3: assert property (@(posedge clk) disable iff (rst)
    !is_csum_word |=> $stable(flags));
  p_crc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (is_csum_word && crc_err) |=> $stable(flags));
  p_read_no_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !is_csum_word) |=> $stable(flags));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> $stable(flags));

  logic unused_rd;
  assign unused_rd = rd_stb;
endmodule

// File: tb/test_edh_flag_capture.sv
module test_edh_flag_capture;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0, rst = 1'b1;
  logic word_valid = 1'b0, crc_err = 1'b0, rd_stb = 1'b0;
  logic [5:0] word_idx = '0;
  logic [9:0] word_data = '0;
  logic [14:0] flags;
  logic upd_busy;

  edh_flag_capture i_edh_flag_capture (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .crc_err(crc_err), .rd_stb(rd_stb),
    .flags(flags), .upd_busy(upd_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  int ref_flags = 0, m_anc = 0, m_ap = 0, m_ff = 0;
  bit ref_busy = 0;
  bit got[3];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check({cur_req, " flags model"}, int'(flags), ref_flags);
    check({cur_req, " R8 busy model"}, int'(upd_busy), int'(ref_busy));
  end

  task automatic model_word(input int idx, input int data, input bit crc);
    if (idx == 0) begin ref_busy = 1; got[0] = 0; got[1] = 0; got[2] = 0; end
    else if (idx == 12) begin m_anc = (data >> 1) & 31; got[0] = 1; end
    else if (idx == 13) begin m_ap  = (data >> 1) & 31; got[1] = 1; end
    else if (idx == 14) begin m_ff  = (data >> 1) & 31; got[2] = 1; end
    if (idx == 22) begin
      if (!crc && ref_busy && got[0] && got[1] && got[2])
        ref_flags = (m_ff << 10) | (m_ap << 5) | m_anc;
      ref_busy = 0;
    end
  endtask

  task automatic send(input int idx, input int data, input bit crc);
    word_valid = 1'b1; word_idx = 6'(idx); word_data = 10'(data); crc_err = crc;
    @(posedge clk);
    model_word(idx, data, crc);
    @(negedge clk);
    word_valid = 1'b0; crc_err = 1'b0;
  endtask

  task automatic idle(input int n, input bit rd);
    for (int i = 0; i < n; i++) begin
      rd_stb = rd;
      @(negedge clk);
    end
    rd_stb = 1'b0;
  endtask

  // first_idx lets a packet start late (missing flag words)
  task automatic packet(input int anc, input int ap, input int ff, input bit crc,
                        input int first_idx, input bit gaps);
    for (int i = first_idx; i <= 22; i++) begin
      int d;
      d = (i * 37) & 10'h3ff;
      if (i == 12) d = 10'h201 | (anc << 1);
      if (i == 13) d = 10'h201 | (ap << 1);
      if (i == 14) d = 10'h201 | (ff << 1);
      send(i, d, (i == 22) ? crc : 1'b0);
      if (i == 6) begin
        check("R8 busy mid packet", int'(upd_busy), (first_idx == 0) ? 1 : int'(ref_busy));
        check("R3 flags stable mid packet", int'(flags), ref_flags);
      end
      if (gaps && (i % 3 == 0)) idle(2, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset flags", int'(flags), 0);
    check("R1 reset busy", int'(upd_busy), 0);

    cur_req = "R2";
    packet(5'h11, 5'h0A, 5'h1F, 1'b0, 0, 1'b0);
    check("R2 area mapping", int'(flags), 15'h7D51);
    check("R8 busy low after csum", int'(upd_busy), 0);

    cur_req = "R5";
    idle(5, 1'b1);
    check("R5 read keeps flags", int'(flags), 15'h7D51);
    cur_req = "R6";
    idle(40, 1'b0);
    check("R6 idle hold", int'(flags), 15'h7D51);

    cur_req = "R7";
    packet(5'h02, 5'h00, 5'h04, 1'b0, 0, 1'b0);
    check("R7 second field replaces", int'(flags), 15'h1002);

    cur_req = "R4";
    packet(5'h1F, 5'h1F, 5'h1F, 1'b1, 0, 1'b0);
    check("R4 crc error blocks", int'(flags), 15'h1002);
    check("R4 busy still clears", int'(upd_busy), 0);

    cur_req = "R10";
    packet(5'h05, 5'h13, 5'h08, 1'b0, 0, 1'b1);
    check("R10 gapped packet", int'(flags), 15'h2265);

    cur_req = "R9";
    for (int i = 0; i <= 13; i++) send(i, (i == 12 || i == 13) ? 10'h03e : 10'h000, 1'b0);
    send(0, 0, 1'b0);
    for (int i = 15; i <= 22; i++) send(i, 0, 1'b0);
    check("R9 restart discards partial", int'(flags), 15'h2265);

    cur_req = "R3";
    packet(5'h00, 5'h1F, 5'h00, 1'b0, 0, 1'b0);
    check("R3 commit after csum", int'(flags), 15'h03E0);
    idle(3, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule